// File: doc/BRIEF.md
# Block-Lock Write Gate for an 8K x 8 Serial Memory

This block stands between the command decoder of a serial memory and the engine that programs its array. The decoder reports when a write command opens, which device it names, whether it targets the control register or the array, and the starting address. The gate then accepts or refuses that command. It judges each data byte that follows and steps the byte address inside a 64-byte page. Every result comes one clock after the stimulus that caused it.

A command opens a session only when all of these hold: the device-select field matches the strap pins, the write-enable latch is set, no reset or inhibit is active, and, for a control-register command, the hardware write-protect is not in force. Inside an array session, each byte is granted or refused according to a 3-bit lock code. The code protects a region taken from the top of the address space. That region is either a fraction of the array or a small fixed number of bytes. A refused byte is dropped without any other sign. A control session takes only one byte. Once a session is open, raising the inhibit does not cut it short.

Top module: `wg_gate`

## Requirements
- R1: A `cmd_start` sampled while idle, with device match, `wel`=1, `inhibit`=0 and no write-protect block, gives `start_ok`=1 for one cycle on the next cycle and `active`=1 from then on. Any other `cmd_start` gives `start_nak`=1. A start while a session is open is refused, and the open session carries on unchanged.
- R2: A start whose `cmd_dev` differs from `sel_pins` is refused.
- R3: A start with `wel`=0 is refused.
- R4: A start with `inhibit`=1 is refused.
- R5: Raising `inhibit` during an open session does not end it. Its bytes are still judged and granted as usual.
- R6: A control start (`cmd_ctrl`=1) is refused when `wp_pin`=1 and `wpen`=1 together. Either one alone does not block it.
- R7: `lock_code` sets the protected region as follows: 000 nothing; 001 0x1800 and above; 010 0x1000 and above; 011 the whole array; 100 0x1FC0 and above; 101 0x1F80 and above; 110 0x1F00 and above; 111 0x1E00 and above.
- R8: Each `cmd_byte` in an array session gives exactly one of `byte_grant` or `byte_refuse` on the next cycle, with `byte_addr` set to the address of that byte. The byte is refused when that address is protected.
- R9: After each array byte, address bits [5:0] increment modulo 64 and bits [12:6] stay fixed.
- R10: In a control session the first byte is granted whatever the lock code. Every later byte in that session is refused.
- R11: A `cmd_stop` ends the session, so `active`=0 on the next cycle. A byte sampled in the same cycle as the stop is still judged. While idle, `cmd_byte` and `cmd_stop` produce no grant and no refuse.
- R12: During and after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_pins | input | 2 | Device-select strap pins |
| cmd_start | input | 1 | Write command opens (one-cycle pulse) |
| cmd_dev | input | 2 | Device-select field of the command |
| cmd_ctrl | input | 1 | 1 = control-register write, 0 = array write |
| cmd_addr | input | 13 | Starting byte address |
| cmd_byte | input | 1 | One data byte arrives (pulse) |
| cmd_stop | input | 1 | Stop condition closes the session |
| wel | input | 1 | Write-enable latch |
| lock_code | input | 3 | Block-lock protection code |
| wp_pin | input | 1 | Hardware write-protect pin |
| wpen | input | 1 | Write-protect enable bit |
| inhibit | input | 1 | Reset or inhibit active |
| start_ok | output | 1 | Command accepted (pulse) |
| start_nak | output | 1 | Command refused (pulse) |
| byte_grant | output | 1 | Byte may be written (pulse) |
| byte_refuse | output | 1 | Byte dropped (pulse) |
| byte_addr | output | 13 | Address of the judged byte |
| active | output | 1 | A write session is open |

## Verification
Every result is due on the cycle after the cycle that sampled its stimulus. `start_ok` and `start_nak` follow the `cmd_start` cycle. `byte_grant`, `byte_refuse` and `byte_addr` follow the `cmd_byte` cycle. `active` changes one cycle after the accepted start or the stop. The bench drives each stimulus at a falling edge, holds it for one rising edge, and reads the outputs at the next falling edge, where they are stable. It then clears the stimulus.

// File: rtl/wg_pkg.sv
package wg_pkg;

  typedef enum logic [2:0] {
    LK_NONE    = 3'd0,
    LK_QUARTER = 3'd1,
    LK_HALF    = 3'd2,
    LK_ALL     = 3'd3,
    LK_FIX1    = 3'd4,
    LK_FIX2    = 3'd5,
    LK_FIX4    = 3'd6,
    LK_FIX8    = 3'd7
  } lock_e;

  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_ARRAY      = 2'd1,
    ST_CTRL_FRESH = 2'd2,
    ST_CTRL_USED  = 2'd3
  } sess_e;

  // low field steps modulo its width, high field is held
  function automatic logic [15:0] page_step(input logic [15:0] a, input int unsigned pw);
    logic [15:0] lo_mask;
    lo_mask = (16'd1 << pw) - 16'd1;
    return (a & ~lo_mask) | ((a + 16'd1) & lo_mask);
  endfunction

endpackage

// File: rtl/wg_admit.sv
module wg_admit #(
  parameter int unsigned SEL_W = 2
) (
  input  logic [SEL_W-1:0] sel_pins,
  input  logic [SEL_W-1:0] cmd_dev,
  input  logic             cmd_ctrl,
  input  logic             wel,
  input  logic             inhibit,
  input  logic             wp_pin,
  input  logic             wpen,
  input  logic             busy,
  output logic             accept
);
  logic dev_match;
  logic ctrl_locked;

  assign dev_match   = (cmd_dev == sel_pins);
  assign ctrl_locked = cmd_ctrl && wp_pin && wpen;

  always_comb begin
    accept = dev_match && wel && !inhibit && !ctrl_locked && !busy;
  end
endmodule

// File: rtl/wg_region.sv
module wg_region
  import wg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned FINE_UNIT = 64
) (
  input  logic [2:0]        lock_code,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned SPAN_W  = ADDR_W + 1;
  localparam logic [SPAN_W-1:0] DEPTH_V = SPAN_W'(1) << ADDR_W;
  localparam logic [SPAN_W-1:0] UNIT_V  = SPAN_W'(FINE_UNIT);

  function automatic logic [SPAN_W-1:0] span_of(input lock_e c);
    case (c)
      LK_QUARTER: return DEPTH_V >> 2;
      LK_HALF:    return DEPTH_V >> 1;
      LK_ALL:     return DEPTH_V;
      LK_FIX1:    return UNIT_V;
      LK_FIX2:    return UNIT_V << 1;
      LK_FIX4:    return UNIT_V << 2;
      LK_FIX8:    return UNIT_V << 3;
      default:    return '0;
    endcase
  endfunction

  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] floor_addr;

  always_comb begin
    span       = span_of(lock_e'(lock_code));
    floor_addr = DEPTH_V - span;
    hit        = (span != '0) && ({1'b0, addr} >= floor_addr);
  end
endmodule

// File: rtl/wg_page_ptr.sv
module wg_page_ptr
  import wg_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  logic [15:0]       wide_next;
  logic [ADDR_W-1:0] stepped;

  always_comb begin
    wide_next = page_step(16'(ptr), PAGE_W);
    stepped   = wide_next[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (load)   ptr <= load_addr;
    else if (step)   ptr <= stepped;
  end
endmodule

// File: rtl/wg_gate.sv
module wg_gate
  import wg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned PAGE_W    = 6,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned FINE_UNIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_pins,
  input  logic              cmd_start,
  input  logic [SEL_W-1:0]  cmd_dev,
  input  logic              cmd_ctrl,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_byte,
  input  logic              cmd_stop,
  input  logic              wel,
  input  logic [2:0]        lock_code,
  input  logic              wp_pin,
  input  logic              wpen,
  input  logic              inhibit,
  output logic              start_ok,
  output logic              start_nak,
  output logic              byte_grant,
  output logic              byte_refuse,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              active
);
  sess_e             sess, sess_nxt;
  logic              accept;
  logic              region_hit;
  logic [ADDR_W-1:0] ptr;
  logic              open_now;
  logic              byte_take;
  logic              grant_now;
  logic              ptr_step;

  wg_admit #(.SEL_W(SEL_W)) u_admit (
    .sel_pins (sel_pins),
    .cmd_dev  (cmd_dev),
    .cmd_ctrl (cmd_ctrl),
    .wel      (wel),
    .inhibit  (inhibit),
    .wp_pin   (wp_pin),
    .wpen     (wpen),
    .busy     (sess != ST_IDLE),
    .accept   (accept)
  );

  wg_region #(.ADDR_W(ADDR_W), .FINE_UNIT(FINE_UNIT)) u_region (
    .lock_code (lock_code),
    .addr      (ptr),
    .hit       (region_hit)
  );

  wg_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (open_now),
    .load_addr (cmd_addr),
    .step      (ptr_step),
    .ptr       (ptr)
  );

  always_comb begin
    open_now  = cmd_start && accept;
    byte_take = cmd_byte && (sess != ST_IDLE);
    ptr_step  = byte_take && (sess == ST_ARRAY);
    case (sess)
      ST_ARRAY:      grant_now = !region_hit;
      ST_CTRL_FRESH: grant_now = 1'b1;
      default:       grant_now = 1'b0;
    endcase
    sess_nxt = sess;
    if (open_now) begin
      sess_nxt = cmd_ctrl ? ST_CTRL_FRESH : ST_ARRAY;
    end else if (sess != ST_IDLE) begin
      if (byte_take && sess == ST_CTRL_FRESH) sess_nxt = ST_CTRL_USED;
      if (cmd_stop) sess_nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sess        <= ST_IDLE;
      start_ok    <= 1'b0;
      start_nak   <= 1'b0;
      byte_grant  <= 1'b0;
      byte_refuse <= 1'b0;
      byte_addr   <= '0;
    end else begin
      sess        <= sess_nxt;
      start_ok    <= open_now;
      start_nak   <= cmd_start && !accept;
      byte_grant  <= byte_take && grant_now;
      byte_refuse <= byte_take && !grant_now;
      if (byte_take) byte_addr <= ptr;
    end
  end

  assign active = (sess != ST_IDLE);
endmodule

// File: rtl/wg_gate_chk.sv
module wg_gate_chk
  import wg_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned PAGE_W = 6,
  parameter int unsigned SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SEL_W-1:0]  sel_pins,
  input logic              cmd_start,
  input logic [SEL_W-1:0]  cmd_dev,
  input logic              cmd_ctrl,
  input logic              cmd_byte,
  input logic              cmd_stop,
  input logic              wel,
  input logic [2:0]        lock_code,
  input logic              wp_pin,
  input logic              wpen,
  input logic              inhibit,
  input logic              start_ok,
  input logic              start_nak,
  input logic              byte_grant,
  input logic              byte_refuse,
  input logic              active,
  input logic              accept,
  input logic              region_hit,
  input logic [1:0]        sess,
  input logic [ADDR_W-1:0] ptr
);
  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) cmd_start && accept |=> start_ok && active); // R1
  AST_DEVSEL_NAK:   assert property (@(posedge clk) disable iff (!rst_n) cmd_start && (cmd_dev != sel_pins) |=> start_nak && !start_ok); // R2
  AST_WEL_NAK:      assert property (@(posedge clk) disable iff (!rst_n) cmd_start && !wel |=> !start_ok); // R3
  AST_INHIBIT_NAK:  assert property (@(posedge clk) disable iff (!rst_n) cmd_start && inhibit |=> !start_ok); // R4
  AST_SESSION_HOLD: assert property (@(posedge clk) disable iff (!rst_n) active && !cmd_stop |=> active); // R5
  AST_WP_NAK:       assert property (@(posedge clk) disable iff (!rst_n) cmd_start && cmd_ctrl && wp_pin && wpen |=> !start_ok); // R6
  AST_LOCK_ALL:     assert property (@(posedge clk) disable iff (!rst_n) cmd_byte && (sess == 2'(ST_ARRAY)) && (lock_code == 3'd3) |=> !byte_grant); // R7
  AST_GRANT_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(byte_grant && byte_refuse)); // R8
  AST_HIT_REFUSE:   assert property (@(posedge clk) disable iff (!rst_n) cmd_byte && (sess == 2'(ST_ARRAY)) && region_hit |=> byte_refuse); // R8
  AST_PAGE_FIXED:   assert property (@(posedge clk) disable iff (!rst_n) active && $past(active) |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])); // R9
  AST_CTRL_ONCE:    assert property (@(posedge clk) disable iff (!rst_n) cmd_byte && (sess == 2'(ST_CTRL_USED)) |=> byte_refuse); // R10
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !active && !cmd_start |=> !byte_grant && !byte_refuse && !active); // R11
  AST_STOP_CLOSE:   assert property (@(posedge clk) disable iff (!rst_n) active && cmd_stop && !cmd_start |=> !active); // R11
endmodule

bind wg_gate wg_gate_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_pins    (sel_pins),
  .cmd_start   (cmd_start),
  .cmd_dev     (cmd_dev),
  .cmd_ctrl    (cmd_ctrl),
  .cmd_byte    (cmd_byte),
  .cmd_stop    (cmd_stop),
  .wel         (wel),
  .lock_code   (lock_code),
  .wp_pin      (wp_pin),
  .wpen        (wpen),
  .inhibit     (inhibit),
  .start_ok    (start_ok),
  .start_nak   (start_nak),
  .byte_grant  (byte_grant),
  .byte_refuse (byte_refuse),
  .active      (active),
  .accept      (accept),
  .region_hit  (region_hit),
  .sess        (sess),
  .ptr         (ptr)
);

// File: tb/tb_wg_gate.sv
module tb_wg_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sel_pins = 2'd1;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_dev = 2'd1;
  logic        cmd_ctrl = 1'b0;
  logic [12:0] cmd_addr = '0;
  logic        cmd_byte = 1'b0;
  logic        cmd_stop = 1'b0;
  logic        wel = 1'b1;
  logic [2:0]  lock_code = 3'd0;
  logic        wp_pin = 1'b0;
  logic        wpen = 1'b0;
  logic        inhibit = 1'b0;
  logic        start_ok, start_nak, byte_grant, byte_refuse, active;
  logic [12:0] byte_addr;

  int vectors = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  wg_gate dut (
    .clk(clk), .rst_n(rst_n), .sel_pins(sel_pins), .cmd_start(cmd_start),
    .cmd_dev(cmd_dev), .cmd_ctrl(cmd_ctrl), .cmd_addr(cmd_addr),
    .cmd_byte(cmd_byte), .cmd_stop(cmd_stop), .wel(wel), .lock_code(lock_code),
    .wp_pin(wp_pin), .wpen(wpen), .inhibit(inhibit), .start_ok(start_ok),
    .start_nak(start_nak), .byte_grant(byte_grant), .byte_refuse(byte_refuse),
    .byte_addr(byte_addr), .active(active)
  );

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // protected address per lock code, written from the region table
  function automatic logic locked(input logic [2:0] c, input logic [12:0] a);
    case (c)
      3'd1: return a[12:11] == 2'b11;
      3'd2: return a[12];
      3'd3: return 1'b1;
      3'd4: return &a[12:6];
      3'd5: return &a[12:7];
      3'd6: return &a[12:8];
      3'd7: return &a[12:9];
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_start(input logic [1:0] dev, input logic ctl, input logic [12:0] a,
                          input logic exp_ok, input string req);
    @(negedge clk);
    cmd_start = 1'b1; cmd_dev = dev; cmd_ctrl = ctl; cmd_addr = a;
    @(negedge clk);
    cmd_start = 1'b0;
    check(req, {12'd0, start_ok}, {12'd0, exp_ok});
    check(req, {12'd0, start_nak}, {12'd0, !exp_ok});
  endtask

  task automatic do_byte(input logic exp_g, input logic exp_r, input logic [12:0] exp_a,
                         input string req);
    @(negedge clk);
    cmd_byte = 1'b1;
    @(negedge clk);
    cmd_byte = 1'b0;
    check(req, {12'd0, byte_grant}, {12'd0, exp_g});
    check(req, {12'd0, byte_refuse}, {12'd0, exp_r});
    if (exp_g || exp_r) check(req, byte_addr, exp_a);
  endtask

  task automatic do_stop(input string req);
    @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    check(req, {12'd0, active}, 13'd0);
  endtask

  task automatic t_reset();
    check("R12 start_ok", {12'd0, start_ok}, 13'd0);
    check("R12 grant", {12'd0, byte_grant | byte_refuse | start_nak}, 13'd0);
    check("R12 active", {12'd0, active}, 13'd0);
    check("R12 addr", byte_addr, 13'd0);
  endtask

  task automatic t_basic();
    do_start(2'd1, 1'b0, 13'h0100, 1'b1, "R1 accept");
    check("R1 active", {12'd0, active}, 13'd1);
    do_byte(1'b1, 1'b0, 13'h0100, "R8 grant");
    do_start(2'd1, 1'b0, 13'h0500, 1'b0, "R1 start while open");
    do_byte(1'b1, 1'b0, 13'h0101, "R1 session unchanged");
    do_stop("R11 stop");
  endtask

  task automatic t_refusals();
    do_start(2'd2, 1'b0, 13'h0000, 1'b0, "R2 devsel");
    wel = 1'b0;
    do_start(2'd1, 1'b0, 13'h0000, 1'b0, "R3 wel");
    wel = 1'b1;
    inhibit = 1'b1;
    do_start(2'd1, 1'b0, 13'h0000, 1'b0, "R4 inhibit");
    inhibit = 1'b0;
    do_start(2'd1, 1'b0, 13'h0040, 1'b1, "R5 open");
    inhibit = 1'b1;
    do_byte(1'b1, 1'b0, 13'h0040, "R5 byte under inhibit");
    check("R5 still active", {12'd0, active}, 13'd1);
    do_stop("R5 stop");
    inhibit = 1'b0;
  endtask

  task automatic t_ctrl();
    wp_pin = 1'b1; wpen = 1'b1;
    do_start(2'd1, 1'b1, 13'h0000, 1'b0, "R6 wp+wpen");
    wpen = 1'b0;
    lock_code = 3'd3;
    do_start(2'd1, 1'b1, 13'h0007, 1'b1, "R6 wp only");
    do_byte(1'b1, 1'b0, 13'h0007, "R10 first ctrl byte");
    do_byte(1'b0, 1'b1, 13'h0007, "R10 second ctrl byte");
    do_stop("R10 stop");
    wp_pin = 1'b0; wpen = 1'b1;
    do_start(2'd1, 1'b1, 13'h0000, 1'b1, "R6 wpen only");
    do_stop("R6 stop");
    wpen = 1'b0; lock_code = 3'd0;
  endtask

  task automatic t_lock();
    for (int c = 0; c < 8; c++) begin
      lock_code = 3'(c);
      for (int k = 0; k < 4; k++) begin
        logic [12:0] a;
        case (k)
          0: a = 13'h1FFF;
          1: a = 13'h0000;
          2: a = (c == 0 || c == 3) ? 13'h17FF : 13'h1000 - 13'd1;
          default: a = (c == 4) ? 13'h1FC0 : (c == 5) ? 13'h1F80 : (c == 6) ? 13'h1F00 :
                       (c == 7) ? 13'h1E00 : (c == 1) ? 13'h1800 : 13'h1000;
        endcase
        do_start(2'd1, 1'b0, a, 1'b1, "R7 open");
        do_byte(!locked(3'(c), a), locked(3'(c), a), a, "R7 region");
        do_stop("R7 stop");
      end
      if (c >= 4) begin
        logic [12:0] b;
        b = (c == 4) ? 13'h1FBF : (c == 5) ? 13'h1F7F : (c == 6) ? 13'h1EFF : 13'h1DFF;
        do_start(2'd1, 1'b0, b, 1'b1, "R8 open");
        do_byte(1'b1, 1'b0, b, "R8 below floor");
        do_stop("R8 stop");
      end
    end
    lock_code = 3'd0;
  endtask

  task automatic t_wrap();
    do_start(2'd1, 1'b0, 13'h1FFE, 1'b1, "R9 open");
    do_byte(1'b1, 1'b0, 13'h1FFE, "R9 byte0");
    do_byte(1'b1, 1'b0, 13'h1FFF, "R9 byte1");
    do_byte(1'b1, 1'b0, 13'h1FC0, "R9 wrapped");
    do_byte(1'b1, 1'b0, 13'h1FC1, "R9 after wrap");
    do_stop("R9 stop");
    lock_code = 3'd4;
    do_start(2'd1, 1'b0, 13'h0A3F, 1'b1, "R9 open2");
    do_byte(1'b1, 1'b0, 13'h0A3F, "R9 page end");
    do_byte(1'b1, 1'b0, 13'h0A00, "R9 page start");
    do_stop("R9 stop2");
    lock_code = 3'd0;
  endtask

  task automatic t_idle();
    do_byte(1'b0, 1'b0, 13'h0000, "R11 idle byte");
    do_stop("R11 idle stop");
    check("R11 idle quiet", {12'd0, byte_grant | byte_refuse}, 13'd0);
    do_start(2'd1, 1'b0, 13'h0123, 1'b1, "R11 open");
    @(negedge clk);
    cmd_byte = 1'b1; cmd_stop = 1'b1;
    @(negedge clk);
    cmd_byte = 1'b0; cmd_stop = 1'b0;
    check("R11 byte with stop", {12'd0, byte_grant}, 13'd1);
    check("R11 byte with stop addr", byte_addr, 13'h0123);
    check("R11 closed", {12'd0, active}, 13'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_refusals();
    t_ctrl();
    t_lock();
    t_wrap();
    t_idle();
    finish_run();
  end
endmodule